// File: doc/BRIEF.md
# Packet Header Rule-Group Classifier

This block sorts each parsed packet header into rule groups. Every group holds a header specification that is fixed when the design is elaborated. The specification covers the protocol number, a source and a destination address prefix, inclusive source and destination port ranges, and an ICMP type. Each field has its own enable, and a cleared enable makes that field a wildcard. Port ranges apply only to TCP and UDP headers. The ICMP type applies only to ICMP headers. A group is active when every enabled field of its specification agrees with the header.

A header is offered together with a one-cycle strobe. The block copies the fields into a capture register and compares them against all groups in a pipelined array, so it can take a new header on every cycle. It then reports a bit vector with one bit per group and every active group set. Alongside the vector it reports the lowest-numbered active group, which software uses as the best applicable group, and a flag that is raised when no group is active. A result strobe marks each new result. The outputs keep their values until the next result arrives.

Top module: `hdrcls_top`

## Requirements
- R1: Header inputs are sampled only on the edge where `hdrValid` is high. Input values on any other cycle do not affect any result.
- R2: Each header accepted on clock edge k produces exactly one result with `resValid` high after edge k+3. Headers on consecutive cycles produce results on consecutive cycles, in input order.
- R3: A group with its protocol check enabled is active only if `hdrProto` equals the stored protocol number. Protocol numbers are ICMP = 1, TCP = 6 and UDP = 17.
- R4: Address checks compare only the top L bits of the address with the stored network, where L is the prefix length (0 to 32). A length of 0 matches any address.
- R5: An enabled port check requires that the protocol is TCP (6) or UDP (17), that `hdrSrcPort` lies in [srcLo, srcHi] and that `hdrDstPort` lies in [dstLo, dstHi], with both bounds inclusive. For any other protocol the check fails.
- R6: An enabled ICMP type check requires that the protocol is ICMP (1) and that `hdrIcmpType` equals the stored type. For any other protocol the check fails.
- R7: Bit g of `activeMask` is 1 exactly when group g is active. Several bits may be set at once.
- R8: `bestGroup` is the index of the lowest set bit of `activeMask`. When no bit is set, `noneActive` is 1 and `bestGroup` is 0. Otherwise `noneActive` is 0.
- R9: After reset, `resValid` is 0, `activeMask` is 0, `bestGroup` is 0 and `noneActive` is 1.
- R10: While `resValid` is low, `activeMask`, `bestGroup` and `noneActive` hold the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hdrValid | input | 1 | Header fields are valid this cycle |
| hdrProto | input | 8 | IP protocol number |
| hdrSrcAddr | input | 32 | Source address |
| hdrDstAddr | input | 32 | Destination address |
| hdrSrcPort | input | 16 | Source port |
| hdrDstPort | input | 16 | Destination port |
| hdrIcmpType | input | 8 | ICMP type |
| resValid | output | 1 | A new result is on the outputs |
| activeMask | output | NUM_GROUPS | One bit per active group |
| bestGroup | output | $clog2(NUM_GROUPS) | Lowest-numbered active group |
| noneActive | output | 1 | No group is active |

## Verification
The bench drives port values that lie exactly on range bounds and just outside them, and address prefixes of length 8, 24 and 32. A design with an off-by-one bound or a wrong mask shift would set or drop a group bit on those headers. ICMP headers are sent to groups that check ports, and non-ICMP headers to groups that check the ICMP type. A design that tested a field without first checking the protocol would then report false activity. The bench also sends back-to-back headers and changes the inputs between strobes. A pipeline that stalled, skewed its stages or sampled inputs late would return results on the wrong cycle or for the wrong header. Idle cycles after each result check that the outputs hold, and a header that matches no group checks the empty-result flag and the zero index.

// File: rtl/hdrcls_pkg.sv
package hdrcls_pkg;

  localparam int ADDR_W     = 32;
  localparam int PORT_W     = 16;
  localparam int PROTO_W    = 8;
  localparam int TYPE_W     = 8;
  localparam int PLEN_W     = $clog2(ADDR_W + 1);
  localparam int PIPE_DEPTH = 4;

  localparam logic [PROTO_W-1:0] PROTO_ICMP = 8'd1;
  localparam logic [PROTO_W-1:0] PROTO_TCP  = 8'd6;
  localparam logic [PROTO_W-1:0] PROTO_UDP  = 8'd17;

  typedef struct packed {
    logic [PROTO_W-1:0] proto;
    logic [ADDR_W-1:0]  srcAddr;
    logic [ADDR_W-1:0]  dstAddr;
    logic [PORT_W-1:0]  srcPort;
    logic [PORT_W-1:0]  dstPort;
    logic [TYPE_W-1:0]  icmpType;
  } hdr_t;

  typedef struct packed {
    logic               protoEn;
    logic [PROTO_W-1:0] proto;
    logic               srcEn;
    logic [ADDR_W-1:0]  srcNet;
    logic [PLEN_W-1:0]  srcLen;
    logic               dstEn;
    logic [ADDR_W-1:0]  dstNet;
    logic [PLEN_W-1:0]  dstLen;
    logic               portEn;
    logic [PORT_W-1:0]  srcLo;
    logic [PORT_W-1:0]  srcHi;
    logic [PORT_W-1:0]  dstLo;
    logic [PORT_W-1:0]  dstHi;
    logic               typeEn;
    logic [TYPE_W-1:0]  icmpType;
  } rule_t;

  typedef struct packed {
    logic capture;
    logic compare;
    logic reduce;
    logic publish;
  } strobe_t;

  typedef enum int {
    F_PROTO = 0,
    F_SRC   = 1,
    F_DST   = 2,
    F_PORT  = 3,
    F_TYPE  = 4,
    F_COUNT = 5
  } field_e;

  function automatic logic [ADDR_W-1:0] prefixMask(input logic [PLEN_W-1:0] len);
    logic [ADDR_W-1:0] m;
    if (len == '0) m = '0;
    else if (int'(len) >= ADDR_W) m = '1;
    else m = {ADDR_W{1'b1}} << (ADDR_W - int'(len));
    return m;
  endfunction

  // Group specifications, fixed at elaboration.
  function automatic rule_t ruleFor(input int g);
    rule_t r;
    r       = '0;
    r.srcHi = '1;
    r.dstHi = '1;
    case (g)
      0: begin
        r.protoEn = 1'b1; r.proto = PROTO_TCP;
        r.dstEn = 1'b1; r.dstNet = 32'h0A00_0000; r.dstLen = 6'd8;
        r.portEn = 1'b1; r.dstLo = 16'd80; r.dstHi = 16'd80;
      end
      1: begin
        r.protoEn = 1'b1; r.proto = PROTO_TCP;
        r.portEn = 1'b1; r.dstLo = 16'd1024; r.dstHi = 16'hFFFF;
      end
      2: begin
        r.protoEn = 1'b1; r.proto = PROTO_UDP;
        r.portEn = 1'b1; r.dstLo = 16'd53; r.dstHi = 16'd53;
      end
      3: begin
        r.protoEn = 1'b1; r.proto = PROTO_ICMP;
        r.typeEn = 1'b1; r.icmpType = 8'd8;
      end
      4: begin
        r.protoEn = 1'b1; r.proto = PROTO_ICMP;
        r.srcEn = 1'b1; r.srcNet = 32'hC0A8_0100; r.srcLen = 6'd24;
      end
      5: begin
        r.dstEn = 1'b1; r.dstNet = 32'h0A01_0203; r.dstLen = 6'd32;
      end
      6: begin
        r.portEn = 1'b1; r.srcLo = 16'd0; r.srcHi = 16'd1023;
      end
      7: begin
        r.typeEn = 1'b1; r.icmpType = 8'd0;
      end
      default: begin
        r.protoEn = 1'b1; r.proto = 8'd250;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hdrcls_ctrl.sv
module hdrcls_ctrl
  import hdrcls_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hdrValid,
  output strobe_t strobe,
  output logic    resValid
);

  logic [PIPE_DEPTH-1:0] stageVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageVld <= '0;
    else       stageVld <= {stageVld[PIPE_DEPTH-2:0], hdrValid};
  end

  always_comb begin
    strobe.capture = hdrValid;
    strobe.compare = stageVld[0];
    strobe.reduce  = stageVld[1];
    strobe.publish = stageVld[2];
    resValid       = stageVld[PIPE_DEPTH-1];
  end

  // R2: fixed latency from accepted header to result strobe
  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |-> ##4 resValid);

  // R2: no result without a header four edges earlier
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> $past(strobe.publish));

endmodule

// File: rtl/hdrcls_grp_cmp.sv
module hdrcls_grp_cmp
  import hdrcls_pkg::*;
#(
  parameter int GROUP = 0
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  hdr_t    hdr,
  output logic    hit
);

  localparam rule_t RULE = ruleFor(GROUP);
  localparam logic [ADDR_W-1:0] SRC_MASK = prefixMask(RULE.srcLen);
  localparam logic [ADDR_W-1:0] DST_MASK = prefixMask(RULE.dstLen);

  logic [F_COUNT-1:0] fieldOk;
  logic [F_COUNT-1:0] fieldQ;
  logic               isL4;
  logic               isIcmp;
  logic               srcPortIn;
  logic               dstPortIn;

  always_comb begin
    isL4      = (hdr.proto == PROTO_TCP) || (hdr.proto == PROTO_UDP);
    isIcmp    = (hdr.proto == PROTO_ICMP);
    srcPortIn = (hdr.srcPort >= RULE.srcLo) && (hdr.srcPort <= RULE.srcHi);
    dstPortIn = (hdr.dstPort >= RULE.dstLo) && (hdr.dstPort <= RULE.dstHi);

    fieldOk[F_PROTO] = !RULE.protoEn || (hdr.proto == RULE.proto);
    fieldOk[F_SRC]   = !RULE.srcEn   || (((hdr.srcAddr ^ RULE.srcNet) & SRC_MASK) == '0);
    fieldOk[F_DST]   = !RULE.dstEn   || (((hdr.dstAddr ^ RULE.dstNet) & DST_MASK) == '0);
    fieldOk[F_PORT]  = !RULE.portEn  || (isL4 && srcPortIn && dstPortIn);
    fieldOk[F_TYPE]  = !RULE.typeEn  || (isIcmp && (hdr.icmpType == RULE.icmpType));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldQ <= '0;
      hit    <= 1'b0;
    end else begin
      if (strobe.compare) fieldQ <= fieldOk;
      if (strobe.reduce)  hit    <= &fieldQ;
    end
  end

  // R5: port-checked groups never pass a header that is neither TCP nor UDP
  a_r5_port_needs_l4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.compare && RULE.portEn && hdr.proto != PROTO_TCP && hdr.proto != PROTO_UDP)
      |=> !fieldQ[F_PORT]);

  // R6: type-checked groups never pass a header that is not ICMP
  a_r6_type_needs_icmp: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.compare && RULE.typeEn && hdr.proto != PROTO_ICMP) |=> !fieldQ[F_TYPE]);

endmodule

// File: rtl/hdrcls_prio.sv
module hdrcls_prio #(
  parameter int NUM_GROUPS = 8,
  localparam int IDX_W = $clog2(NUM_GROUPS)
) (
  input  logic [NUM_GROUPS-1:0] mask,
  output logic [IDX_W-1:0]      idx,
  output logic                  none
);

  always_comb begin
    idx  = '0;
    none = ~|mask;
    for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/hdrcls_dp.sv
module hdrcls_dp
  import hdrcls_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  localparam int IDX_W = $clog2(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  hdr_t                  hdrIn,
  output logic [NUM_GROUPS-1:0] activeMask,
  output logic [IDX_W-1:0]      bestGroup,
  output logic                  noneActive
);

  hdr_t                  hdrQ;
  logic [NUM_GROUPS-1:0] hitVec;
  logic [IDX_W-1:0]      lowIdx;
  logic                  lowNone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               hdrQ <= '0;
    else if (strobe.capture) hdrQ <= hdrIn;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    hdrcls_grp_cmp #(.GROUP(g)) uCmp (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .hdr    (hdrQ),
      .hit    (hitVec[g])
    );
  end

  hdrcls_prio #(.NUM_GROUPS(NUM_GROUPS)) uPrio (
    .mask (hitVec),
    .idx  (lowIdx),
    .none (lowNone)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMask <= '0;
      bestGroup  <= '0;
      noneActive <= 1'b1;
    end else if (strobe.publish) begin
      activeMask <= hitVec;
      bestGroup  <= lowIdx;
      noneActive <= lowNone;
    end
  end

  // R1: the captured header changes only on an accepted strobe
  a_r1_capture_only: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(hdrQ));

  // R8: the reported group is one of the active ones
  a_r8_best_is_active: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish |=> (noneActive || activeMask[bestGroup]));

  // R8: nothing below the reported group is active
  a_r8_best_is_lowest: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish |=> ((activeMask & ~({NUM_GROUPS{1'b1}} << bestGroup)) == '0));

  // R8: empty flag agrees with the mask
  a_r8_none_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish |=> (noneActive == (activeMask == '0)));

  // R8: empty result reports index zero
  a_r8_none_idx_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish |=> (!noneActive || bestGroup == '0));

  // R10: outputs hold between results
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.publish |=> ($stable(activeMask) && $stable(bestGroup) && $stable(noneActive)));

endmodule

// File: rtl/hdrcls_top.sv
module hdrcls_top
  import hdrcls_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  localparam int IDX_W = $clog2(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hdrValid,
  input  logic [7:0]            hdrProto,
  input  logic [31:0]           hdrSrcAddr,
  input  logic [31:0]           hdrDstAddr,
  input  logic [15:0]           hdrSrcPort,
  input  logic [15:0]           hdrDstPort,
  input  logic [7:0]            hdrIcmpType,
  output logic                  resValid,
  output logic [NUM_GROUPS-1:0] activeMask,
  output logic [IDX_W-1:0]      bestGroup,
  output logic                  noneActive
);

  strobe_t strobe;
  hdr_t    hdrIn;

  always_comb begin
    hdrIn.proto    = hdrProto;
    hdrIn.srcAddr  = hdrSrcAddr;
    hdrIn.dstAddr  = hdrDstAddr;
    hdrIn.srcPort  = hdrSrcPort;
    hdrIn.dstPort  = hdrDstPort;
    hdrIn.icmpType = hdrIcmpType;
  end

  hdrcls_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hdrValid (hdrValid),
    .strobe   (strobe),
    .resValid (resValid)
  );

  hdrcls_dp #(.NUM_GROUPS(NUM_GROUPS)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hdrIn      (hdrIn),
    .activeMask (activeMask),
    .bestGroup  (bestGroup),
    .noneActive (noneActive)
  );

endmodule

// File: tb/sim_hdrcls_top.sv
module sim_hdrcls_top;
  import hdrcls_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NG = 8;
  localparam int LAT = 4;

  typedef struct {
    logic [NG-1:0] mask;
    logic [2:0]    best;
    logic          none;
    int            cyc;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hdrValid = 1'b0;
  logic [7:0]    hdrProto = '0;
  logic [31:0]   hdrSrcAddr = '0;
  logic [31:0]   hdrDstAddr = '0;
  logic [15:0]   hdrSrcPort = '0;
  logic [15:0]   hdrDstPort = '0;
  logic [7:0]    hdrIcmpType = '0;
  logic          resValid;
  logic [NG-1:0] activeMask;
  logic [2:0]    bestGroup;
  logic          noneActive;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  bit seenAny = 0;
  logic [NG-1:0] lastMask;
  logic [2:0]    lastBest;
  logic          lastNone;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hdrcls_top #(.NUM_GROUPS(NG)) u0 (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrProto(hdrProto),
    .hdrSrcAddr(hdrSrcAddr), .hdrDstAddr(hdrDstAddr), .hdrSrcPort(hdrSrcPort),
    .hdrDstPort(hdrDstPort), .hdrIcmpType(hdrIcmpType), .resValid(resValid),
    .activeMask(activeMask), .bestGroup(bestGroup), .noneActive(noneActive)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit inPrefix(input logic [31:0] a, input logic [31:0] n, input int len);
    for (int b = 0; b < 32; b++) begin
      if (b >= 32 - len && a[b] != n[b]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [NG-1:0] model(input hdr_t h);
    logic [NG-1:0] m;
    m = '0;
    for (int g = 0; g < NG; g++) begin
      rule_t r;
      bit ok;
      r  = ruleFor(g);
      ok = 1'b1;
      if (r.protoEn && h.proto != r.proto) ok = 1'b0;
      if (r.srcEn && !inPrefix(h.srcAddr, r.srcNet, int'(r.srcLen))) ok = 1'b0;
      if (r.dstEn && !inPrefix(h.dstAddr, r.dstNet, int'(r.dstLen))) ok = 1'b0;
      if (r.portEn) begin
        if (!(h.proto == 8'd6 || h.proto == 8'd17)) ok = 1'b0;
        if (h.srcPort < r.srcLo || h.srcPort > r.srcHi) ok = 1'b0;
        if (h.dstPort < r.dstLo || h.dstPort > r.dstHi) ok = 1'b0;
      end
      if (r.typeEn && !(h.proto == 8'd1 && h.icmpType == r.icmpType)) ok = 1'b0;
      m[g] = ok;
    end
    return m;
  endfunction

  function automatic hdr_t mk(input logic [7:0] p, input logic [31:0] s, input logic [31:0] d,
                              input logic [15:0] sp, input logic [15:0] dp, input logic [7:0] t);
    hdr_t h;
    h.proto = p; h.srcAddr = s; h.dstAddr = d;
    h.srcPort = sp; h.dstPort = dp; h.icmpType = t;
    return h;
  endfunction

  // Driver: present one header on the next edge and queue its expected result.
  task automatic send(input hdr_t h, input logic [NG-1:0] want, input string tag);
    exp_t e;
    logic [NG-1:0] m;
    @(negedge clk);
    m = model(h);
    check(m == want, {tag, " bench model vs hand value"}, longint'(m), longint'(want));
    hdrValid = 1'b1;
    hdrProto = h.proto; hdrSrcAddr = h.srcAddr; hdrDstAddr = h.dstAddr;
    hdrSrcPort = h.srcPort; hdrDstPort = h.dstPort; hdrIcmpType = h.icmpType;
    e.mask = m;
    e.none = (m == '0);
    e.best = 3'd0;
    for (int g = NG - 1; g >= 0; g--) if (m[g]) e.best = 3'(g);
    e.cyc = cyc + LAT;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Idle cycles with junk on the header pins (R1: must not be sampled).
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hdrValid = 1'b0;
      hdrProto = 8'd1; hdrSrcAddr = 32'hC0A8_0101; hdrDstAddr = 32'h0A01_0203;
      hdrSrcPort = 16'd7; hdrDstPort = 16'd80; hdrIcmpType = 8'd8;
    end
  endtask

  // Monitor: compare results as they appear; check holding between them.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (resValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 result without header", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(activeMask == e.mask, {"R7 active mask, ", e.tag}, longint'(activeMask), longint'(e.mask));
          check(bestGroup == e.best, {"R8 best group, ", e.tag}, longint'(bestGroup), longint'(e.best));
          check(noneActive == e.none, {"R8 none flag, ", e.tag}, longint'(noneActive), longint'(e.none));
          check(cyc == e.cyc, {"R2 result cycle, ", e.tag}, longint'(cyc), longint'(e.cyc));
        end
        seenAny  <= 1'b1;
        lastMask <= activeMask;
        lastBest <= bestGroup;
        lastNone <= noneActive;
      end else if (seenAny) begin
        check(activeMask == lastMask && bestGroup == lastBest && noneActive == lastNone,
              "R10 outputs hold while idle", longint'(activeMask), longint'(lastMask));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R9: reset values
    check(resValid == 1'b0, "R9 resValid in reset", longint'(resValid), 0);
    check(activeMask == '0, "R9 mask in reset", longint'(activeMask), 0);
    check(bestGroup == '0, "R9 best in reset", longint'(bestGroup), 0);
    check(noneActive == 1'b1, "R9 none in reset", longint'(noneActive), 1);
    rstN = 1'b1;
    idle(2);

    // R3 / R4: TCP to 10.1.2.3:80 hits the /8 web group and the /32 host group
    send(mk(8'd6, 32'h0102_0304, 32'h0A01_0203, 16'd5000, 16'd80, 8'd0), 8'b0010_0001, "R3 tcp web");
    idle(3);
    // R3: same host but protocol 50 leaves only the protocol-wildcard /32 group
    send(mk(8'd50, 32'h0102_0304, 32'h0A01_0203, 16'd10, 16'd80, 8'd0), 8'b0010_0000, "R3 proto wildcard, R5 port needs l4");
    // R2: back-to-back stream from here
    send(mk(8'd6, 32'h0102_0304, 32'h0A09_0909, 16'd1023, 16'd1024, 8'd0), 8'b0100_0010, "R5 low bound 1024 and src 1023");
    send(mk(8'd17, 32'h0808_0808, 32'h0808_0808, 16'd53, 16'd53, 8'd0), 8'b0100_0100, "R5 udp exact port");
    send(mk(8'd6, 32'h0102_0304, 32'h0A00_0001, 16'd2000, 16'd79, 8'd0), 8'b0000_0000, "R8 none active, R5 port 79");
    send(mk(8'd6, 32'h0102_0304, 32'h0A00_0001, 16'd1024, 16'd81, 8'd0), 8'b0000_0000, "R5 src 1024 just out");
    send(mk(8'd6, 32'h0102_0304, 32'h0B00_0001, 16'd0, 16'd65535, 8'd0), 8'b0100_0010, "R5 top and zero bounds");
    send(mk(8'd6, 32'h0102_0304, 32'h0B00_0001, 16'd9, 16'd80, 8'd0), 8'b0100_0000, "R4 dst outside /8");
    send(mk(8'd1, 32'hC0A8_0107, 32'h0A01_0203, 16'd5, 16'd53, 8'd8), 8'b0011_1000, "R6 icmp echo, R4 /24 src");
    send(mk(8'd1, 32'hC0A8_01FF, 32'h0102_0304, 16'd5, 16'd80, 8'd0), 8'b1001_0000, "R6 icmp type zero");
    send(mk(8'd1, 32'hC0A8_0201, 32'h0102_0304, 16'd5, 16'd80, 8'd0), 8'b1000_0000, "R4 /24 miss, R7 single high bit");
    send(mk(8'd17, 32'hC0A8_0107, 32'h0A01_0202, 16'd100, 16'd53, 8'd0), 8'b0100_0100, "R6 type ignored on udp, R4 /32 miss");
    idle(2);
    // R1: junk inputs while idle must not leak into the next result
    send(mk(8'd50, 32'h0B00_0001, 32'h0B00_0001, 16'd7, 16'd80, 8'd8), 8'b0000_0000, "R1 junk between strobes");
    idle(6);

    while (expQ.size() != 0) @(negedge clk);
    idle(3);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule